// File: doc/BRIEF.md
# Physical memory protection checker

This block decides whether a physical memory access may proceed. Each cycle it takes an address, a size, a kind (fetch, load or store) and a privilege level, and checks them against a small table of protection regions. Each region is a base/limit window counted in 4-byte granules and carries read, write and execute rights plus a lock flag. Regions are scanned by index, lowest first. The first region that touches any granule of the access settles the verdict. If no region touches the access, a fallback rule applies. That rule depends on the privilege level and on two security controls: one that forbids unmatched accesses entirely and one that locks down unmatched fetches.

Alongside the access verdict, the block reports whether a naturally aligned region of 2^PAGE_SHIFT bytes is treated uniformly by every protection region. A translation cache can use this bit to decide whether a whole page may be cached with a single permission result. The regions are loaded through a plain write port. A region whose lock flag is set cannot be rewritten until reset.

Both results are registered and appear one clock after the inputs that produced them.

Top module: `pmp_checker`

## Requirements
- R1: When built with NUM_ENTRIES = 0, every access is allowed and the region output is always 1 once reset has been released.
- R2: While rst is high, acc_ok and region_uniform read 0. Reset also clears every region to base 0, limit 0, no rights and unlocked.
- R3: Regions are scanned from index 0 upward, and the first region that matches any granule of the access alone decides the verdict, even when a higher-indexed region would decide differently.
- R4: acc_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. An 8-byte access checks the granule of acc_addr and the next granule. The smaller sizes check only the granule of acc_addr. A granule g (address bits above bit 1) matches a region when base <= g < limit, so a region with limit <= base matches nothing.
- R5: If the deciding region matches some but not all of the checked granules, the access is denied.
- R6: If the deciding region matches all checked granules, the region's rights decide. acc_kind 0 (fetch) needs execute (cfg_perm bit 2), 1 (load) needs read (bit 0), and 2 or 3 (store) needs write (bit 1). At machine level (acc_priv 3), an unlocked region allows every kind.
- R7: If no region matches, the access is allowed only when acc_priv is 3, sec_whitelist is 0, and either sec_lockdown is 0 or the access is not a fetch.
- R8: region_uniform is 0 exactly when some non-empty region, of any index, overlaps part but not all of the granules of the 2^PAGE_SHIFT-byte block that contains region_addr. The low PAGE_SHIFT bits of region_addr are ignored.
- R9: A write with cfg_we = 1 replaces the base, limit, rights and lock flag of region cfg_idx at the clock edge. The write is ignored if that region is locked, so a locked region stays unchanged until reset.
- R10: Both outputs reflect the inputs and the region table sampled at one rising edge and hold from that edge until the next. A write at an edge affects verdicts only from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | IDX_W | Region index to write |
| cfg_base | input | ADDR_W-2 | First granule of the region |
| cfg_limit | input | ADDR_W-2 | Granule one past the region |
| cfg_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| cfg_lock | input | 1 | Lock flag for the written region |
| sec_lockdown | input | 1 | Deny unmatched machine-level fetches |
| sec_whitelist | input | 1 | Deny all unmatched accesses |
| acc_addr | input | ADDR_W | Access byte address |
| acc_size | input | 2 | Access size code |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 or 3 store |
| acc_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| region_addr | input | ADDR_W | Address inside the block queried for uniformity |
| acc_ok | output | 1 | Registered access verdict |
| region_uniform | output | 1 | Registered uniformity flag |

## Verification
Each verdict and uniformity flag is due exactly one rising edge after its inputs are applied. A region write lands on that same edge, so it is reflected only in results for inputs applied afterwards. The bench drives inputs on the falling edge and predicts both results from the region table as it stood before that cycle's write. It then updates its own table, waits for the rising edge, and compares on the next falling edge. A second instance built with no regions is compared in the same cycle.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  // log2 of the protection granule in bytes
  localparam int unsigned GRAN_LOG2 = 2;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_WRITE = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef struct packed {
    logic lock;
    logic x;
    logic w;
    logic r;
  } perm_t;

  // rights of one region for an access kind at a privilege level
  function automatic logic perm_grants(perm_t p, acc_kind_e k, priv_e m);
    logic ok;
    if (m == PRIV_MACH && !p.lock) begin
      ok = 1'b1;
    end else begin
      case (k)
        ACC_FETCH: ok = p.x;
        ACC_LOAD:  ok = p.r;
        default:   ok = p.w;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/pmp_entry_file.sv
module pmp_entry_file
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned GW          = 30,
  parameter int unsigned IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [GW-1:0]    wr_base,
  input  logic [GW-1:0]    wr_limit,
  input  perm_t            wr_perm,
  output logic [GW-1:0]    base_o  [NUM_ENTRIES],
  output logic [GW-1:0]    limit_o [NUM_ENTRIES],
  output perm_t            perm_o  [NUM_ENTRIES]
);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(i)) && !perm_o[i].lock;

    always_ff @(posedge clk) begin
      if (rst) begin
        base_o[i]  <= '0;
        limit_o[i] <= '0;
        perm_o[i]  <= '0;
      end else if (hit_wr) begin
        base_o[i]  <= wr_base;
        limit_o[i] <= wr_limit;
        perm_o[i]  <= wr_perm;
      end
    end

    // a locked slot keeps every field until reset
    assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      perm_o[i].lock |=> ($stable(base_o[i]) && $stable(limit_o[i]) && $stable(perm_o[i])));
  end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_pkg::*;
#(
  parameter int unsigned GW           = 30,
  parameter int unsigned REGION_GRANS = 1024
) (
  input  logic      [GW-1:0] base,
  input  logic      [GW-1:0] limit,
  input  perm_t              perm,
  input  logic      [GW-1:0] gran0,
  input  logic               two_gran,
  input  acc_kind_e          kind,
  input  priv_e              priv,
  input  logic      [GW-1:0] region_g,
  output logic               hit_any,
  output logic               hit_all,
  output logic               grants,
  output logic               straddle
);

  logic [GW-1:0] gran1;
  logic          m0, m1;
  logic [GW:0]   r_lo, r_hi, b_ext, l_ext;
  logic          live, overlaps, covers;

  assign gran1 = gran0 + GW'(1);
  assign m0    = (gran0 >= base) && (gran0 < limit);
  assign m1    = (gran1 >= base) && (gran1 < limit);

  assign hit_any = m0 || (two_gran && m1);
  assign hit_all = m0 && (!two_gran || m1);
  assign grants  = perm_grants(perm, kind, priv);

  assign r_lo  = {1'b0, region_g};
  assign r_hi  = r_lo + (GW+1)'(REGION_GRANS);
  assign b_ext = {1'b0, base};
  assign l_ext = {1'b0, limit};

  assign live     = limit > base;
  assign overlaps = live && (b_ext < r_hi) && (l_ext > r_lo);
  assign covers   = (b_ext <= r_lo) && (l_ext >= r_hi);
  assign straddle = overlaps && !covers;

endmodule

// File: rtl/pmp_priority.sv
module pmp_priority #(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic [NUM_ENTRIES-1:0] hit_any,
  input  logic [NUM_ENTRIES-1:0] hit_all,
  input  logic [NUM_ENTRIES-1:0] grants,
  output logic                   found,
  output logic                   partial,
  output logic                   verdict
);

  always_comb begin
    found   = 1'b0;
    partial = 1'b0;
    verdict = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && hit_any[i]) begin
        found   = 1'b1;
        partial = !hit_all[i];
        verdict = hit_all[i] && grants[i];
      end
    end
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAGE_SHIFT  = 12,
  localparam int unsigned GW         = ADDR_W - GRAN_LOG2,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [GW-1:0]     cfg_base,
  input  logic [GW-1:0]     cfg_limit,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_lock,
  input  logic              sec_lockdown,
  input  logic              sec_whitelist,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_priv,
  input  logic [ADDR_W-1:0] region_addr,
  output logic              acc_ok,
  output logic              region_uniform
);

  localparam int unsigned REGION_GRANS = 1 << (PAGE_SHIFT - GRAN_LOG2);

  if (NUM_ENTRIES == 0) begin : g_empty
    logic unused_in;
    assign unused_in = ^{cfg_we, cfg_idx, cfg_base, cfg_limit, cfg_perm, cfg_lock,
                         sec_lockdown, sec_whitelist, acc_addr, acc_size, acc_kind,
                         acc_priv, region_addr};

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_ok         <= 1'b0;
        region_uniform <= 1'b0;
      end else begin
        acc_ok         <= 1'b1;
        region_uniform <= 1'b1;
      end
    end

    assert_empty_allows_R1: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (acc_ok && region_uniform));

  end else begin : g_table
    logic [GW-1:0] ent_base  [NUM_ENTRIES];
    logic [GW-1:0] ent_limit [NUM_ENTRIES];
    perm_t         ent_perm  [NUM_ENTRIES];
    perm_t         wr_perm;

    logic [GW-1:0]          gran0, region_g;
    logic                   two_gran;
    acc_kind_e              kind;
    priv_e                  priv;
    logic [NUM_ENTRIES-1:0] hit_any, hit_all, grants, straddle;
    logic                   found, partial, verdict, fallback_ok;
    logic                   unused_low;

    assign wr_perm  = '{lock: cfg_lock, x: cfg_perm[2], w: cfg_perm[1], r: cfg_perm[0]};
    assign gran0    = acc_addr[ADDR_W-1:GRAN_LOG2];
    assign two_gran = (acc_size == 2'd3);
    assign region_g = {region_addr[ADDR_W-1:PAGE_SHIFT], {(PAGE_SHIFT-GRAN_LOG2){1'b0}}};
    assign kind     = acc_kind_e'(acc_kind);
    assign priv     = priv_e'(acc_priv);
    assign unused_low = ^{acc_addr[GRAN_LOG2-1:0], region_addr[PAGE_SHIFT-1:0]};

    pmp_entry_file #(
      .NUM_ENTRIES(NUM_ENTRIES),
      .GW         (GW),
      .IDX_W      (IDX_W)
    ) u_file (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_base (cfg_base),
      .wr_limit(cfg_limit),
      .wr_perm (wr_perm),
      .base_o  (ent_base),
      .limit_o (ent_limit),
      .perm_o  (ent_perm)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
      pmp_entry_match #(
        .GW          (GW),
        .REGION_GRANS(REGION_GRANS)
      ) u_match (
        .base    (ent_base[e]),
        .limit   (ent_limit[e]),
        .perm    (ent_perm[e]),
        .gran0   (gran0),
        .two_gran(two_gran),
        .kind    (kind),
        .priv    (priv),
        .region_g(region_g),
        .hit_any (hit_any[e]),
        .hit_all (hit_all[e]),
        .grants  (grants[e]),
        .straddle(straddle[e])
      );
    end

    pmp_priority #(
      .NUM_ENTRIES(NUM_ENTRIES)
    ) u_prio (
      .hit_any(hit_any),
      .hit_all(hit_all),
      .grants (grants),
      .found  (found),
      .partial(partial),
      .verdict(verdict)
    );

    assign fallback_ok = (priv == PRIV_MACH) && !sec_whitelist &&
                         (!sec_lockdown || kind != ACC_FETCH);

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_ok         <= 1'b0;
        region_uniform <= 1'b0;
      end else begin
        acc_ok         <= found ? verdict : fallback_ok;
        region_uniform <= ~|straddle;
      end
    end

    assert_partial_deny_R5: assert property (@(posedge clk) disable iff (rst)
      (found && partial) |=> !acc_ok);

    assert_nomatch_low_priv_R7: assert property (@(posedge clk) disable iff (rst)
      (!found && acc_priv != PRIV_MACH) |=> !acc_ok);

    assert_nomatch_whitelist_R7: assert property (@(posedge clk) disable iff (rst)
      (!found && sec_whitelist) |=> !acc_ok);
  end

endmodule

// File: tb/test_pmp_checker.sv
module test_pmp_checker;

  localparam int NE = 8;
  localparam int AW = 32;
  localparam int GW = 30;
  localparam int PS = 6;
  localparam int IW = 3;
  localparam int RG = 1 << (PS - 2);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [GW-1:0] cfg_base = '0, cfg_limit = '0;
  logic [2:0]    cfg_perm = '0;
  logic          cfg_lock = 1'b0;
  logic          sec_lockdown = 1'b0, sec_whitelist = 1'b0;
  logic [AW-1:0] acc_addr = '0, region_addr = '0;
  logic [1:0]    acc_size = '0, acc_kind = '0, acc_priv = '0;
  logic          acc_ok, region_uniform, z_ok, z_uni;

  pmp_checker #(.NUM_ENTRIES(NE), .ADDR_W(AW), .PAGE_SHIFT(PS)) i_pmp_checker (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_lock(cfg_lock),
    .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .region_addr(region_addr), .acc_ok(acc_ok), .region_uniform(region_uniform));

  pmp_checker #(.NUM_ENTRIES(0), .ADDR_W(AW), .PAGE_SHIFT(PS)) i_pmp_checker_zero (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx[0:0]), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_perm(cfg_perm), .cfg_lock(cfg_lock),
    .sec_lockdown(sec_lockdown), .sec_whitelist(sec_whitelist), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .region_addr(region_addr), .acc_ok(z_ok), .region_uniform(z_uni));

  // behavioural model of the region table
  logic [GW-1:0] m_base [NE];
  logic [GW-1:0] m_limit[NE];
  logic [2:0]    m_perm [NE];
  bit            m_lock [NE];
  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(string tag, string what, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NE; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_perm[i] = '0; m_lock[i] = 1'b0;
    end
  endtask

  function automatic void predict(output bit ok, output string tag);
    logic [GW-1:0] g0, g1;
    bit two;
    g0  = acc_addr[AW-1:2];
    g1  = g0 + 1'b1;
    two = (acc_size == 2'd3);
    for (int i = 0; i < NE; i++) begin
      bit m0, m1;
      m0 = (g0 >= m_base[i]) && (g0 < m_limit[i]);
      m1 = (g1 >= m_base[i]) && (g1 < m_limit[i]);
      if (m0 || (two && m1)) begin
        if (!(m0 && (!two || m1))) begin
          ok = 1'b0; tag = "R5";
        end else begin
          if (acc_priv == 2'd3 && !m_lock[i]) ok = 1'b1;
          else if (acc_kind == 2'd0) ok = m_perm[i][2];
          else if (acc_kind == 2'd1) ok = m_perm[i][0];
          else ok = m_perm[i][1];
          tag = (i > 0) ? "R3" : (two ? "R4" : "R6");
        end
        return;
      end
    end
    ok  = (acc_priv == 2'd3) && !sec_whitelist && (!sec_lockdown || acc_kind != 2'd0);
    tag = "R7";
  endfunction

  function automatic bit predict_uni();
    longint r0, r1;
    r0 = longint'(region_addr >> PS) << (PS - 2);
    r1 = r0 + RG;
    for (int i = 0; i < NE; i++) begin
      longint b, l;
      b = longint'(m_base[i]);
      l = longint'(m_limit[i]);
      if (l > b && b < r1 && l > r0 && !(b <= r0 && l >= r1)) return 1'b0;
    end
    return 1'b1;
  endfunction

  // one clock: predict from the table before this edge's write, then compare
  // one rising edge later (R10), on the falling edge
  task automatic cycle(string phase);
    bit ok, uni;
    string tag;
    predict(ok, tag);
    uni = predict_uni();
    if (cfg_we && int'(cfg_idx) < NE && !m_lock[cfg_idx]) begin
      m_base[cfg_idx]  = cfg_base;
      m_limit[cfg_idx] = cfg_limit;
      m_perm[cfg_idx]  = cfg_perm;
      m_lock[cfg_idx]  = cfg_lock;
    end
    @(posedge clk);
    @(negedge clk);
    check({phase, "R10/", tag}, "acc_ok", acc_ok, ok);
    check({phase, "R8"}, "region_uniform", region_uniform, uni);
    check("R1", "zero-entry acc_ok", z_ok, 1'b1);
    check("R1", "zero-entry region_uniform", z_uni, 1'b1);
    cfg_we = 1'b0;
  endtask

  task automatic acc(logic [AW-1:0] a, logic [1:0] sz, logic [1:0] k, logic [1:0] p, string phase);
    acc_addr = a; acc_size = sz; acc_kind = k; acc_priv = p;
    cycle(phase);
  endtask

  task automatic prog(int idx, int b, int l, logic [2:0] perm, logic lk, string phase);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_base = GW'(b); cfg_limit = GW'(l);
    cfg_perm = perm; cfg_lock = lk;
    cycle(phase);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    model_clear();
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R2", "acc_ok in reset", acc_ok, 1'b0);
      check("R2", "region_uniform in reset", region_uniform, 1'b0);
      check("R2", "zero-entry acc_ok in reset", z_ok, 1'b0);
    end
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();
    region_addr = 32'h40;

    // R2/R7: cleared table, fallback rule
    acc(32'h40, 2'd2, 2'd1, 2'd3, "R2 ");
    acc(32'h40, 2'd2, 2'd1, 2'd0, "R7 ");
    sec_lockdown = 1'b1;
    acc(32'h40, 2'd2, 2'd0, 2'd3, "R7 ");
    acc(32'h40, 2'd2, 2'd2, 2'd3, "R7 ");
    sec_lockdown = 1'b0; sec_whitelist = 1'b1;
    acc(32'h40, 2'd2, 2'd1, 2'd3, "R7 ");
    sec_whitelist = 1'b0;

    // R9: region 0 read-only [16,32), region 1 all rights [0,64)
    prog(0, 16, 32, 3'b001, 1'b0, "R9 ");
    prog(1, 0, 64, 3'b111, 1'b0, "R9 ");
    acc(32'h40, 2'd2, 2'd1, 2'd0, "R6 ");
    acc(32'h40, 2'd2, 2'd2, 2'd0, "R3 ");
    acc(32'h10, 2'd2, 2'd2, 2'd0, "R3 ");
    acc(32'h40, 2'd2, 2'd0, 2'd1, "R6 ");
    acc(32'h7C, 2'd3, 2'd1, 2'd0, "R5 ");
    acc(32'h7E, 2'd2, 2'd1, 2'd0, "R4 ");
    acc(32'h78, 2'd3, 2'd1, 2'd0, "R4 ");
    acc(32'h40, 2'd2, 2'd2, 2'd3, "R6 ");

    // R8: lower-priority partial overlap clears the flag
    region_addr = 32'h80;
    acc(32'h40, 2'd0, 2'd1, 2'd0, "R8 ");
    region_addr = 32'h47;
    prog(5, 20, 24, 3'b111, 1'b0, "R8 ");
    acc(32'h40, 2'd1, 2'd1, 2'd0, "R8 ");
    region_addr = 32'h100;
    acc(32'h40, 2'd1, 2'd1, 2'd0, "R8 ");

    // R9: lock region 0, then try to rewrite it
    prog(0, 16, 32, 3'b001, 1'b1, "R9 ");
    acc(32'h40, 2'd2, 2'd2, 2'd3, "R9 ");
    prog(0, 0, 8, 3'b111, 1'b0, "R9 ");
    acc(32'h40, 2'd2, 2'd2, 2'd3, "R9 ");
    acc(32'h40, 2'd2, 2'd1, 2'd0, "R9 ");
    acc(32'h04, 2'd2, 2'd2, 2'd3, "R9 ");

    // mixed traffic with periodic resets
    for (int k = 0; k < 3000; k++) begin
      int b;
      int pr;
      if (k % 1000 == 999) do_reset();
      b = $urandom % 128;
      cfg_we    = ($urandom % 6 == 0);
      cfg_idx   = IW'($urandom % NE);
      cfg_base  = GW'(b);
      cfg_limit = GW'(($urandom % 5 == 0) ? ($urandom % 128) : (b + $urandom % 40));
      cfg_perm  = 3'($urandom);
      cfg_lock  = ($urandom % 20 == 0);
      sec_lockdown  = ($urandom % 4 == 0);
      sec_whitelist = ($urandom % 4 == 0);
      region_addr   = AW'($urandom % 1024);
      pr = $urandom % 3;
      acc_addr = AW'($urandom % 640);
      acc_size = 2'($urandom);
      acc_kind = 2'($urandom);
      acc_priv = (pr == 2) ? 2'd3 : 2'(pr);
      cycle("mix ");
    end

    finish_run();
  end

endmodule